// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block sits beside a small processor core and governs its two low-power states. When the core executes its power-save instruction it raises a request with a one-bit mode select. Sleep stops both the CPU clock and the peripheral clock. Idle stops only the CPU clock, so the system and peripheral clocks keep running, and it clears the watchdog on entry.

While the core is parked, the block watches three kinds of event: enabled interrupt requests that carry a nonzero priority, non-power-on reset sources, and a watchdog time-out. When one of these events wakes the core, the block restores the clocks. For an interrupt wake it compares the winning source's priority with the current CPU priority. It then pulses either a resume strobe, which continues at the instruction after the power-save instruction, or an exception-entry strobe, which vectors to the handler. Two sticky flags record that the core was asleep and that a watchdog time-out caused the wake. Only a power-on reset clears them.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After power-on reset (`por_n` low), `cpu_clk_en` and `per_clk_en` are 1, and `resume`, `exc_req`, `wdt_clr`, `sleep_flag` and `wdto_flag` are 0.
- R2: A `ps_req` sampled in the running state enters Sleep when `ps_mode` is 0, making both clock enables 0 from the next cycle. It enters Idle when `ps_mode` is 1, making `cpu_clk_en` 0 and leaving `per_clk_en` at 1. `wdt_clr` is a one-cycle pulse in the first Idle cycle and stays 0 on Sleep entry.
- R3: A `ps_req` sampled while in Sleep or Idle is ignored: the clock enables do not change.
- R4: Source i qualifies as a wake source only when `irq_en[i]` and `irq_pend[i]` are both 1 and its priority field `irq_prio[i*PW +: PW]` is nonzero. A source with priority 0, a disabled source, or a source that is not pending never ends Sleep or Idle.
- R5: When several sources qualify, the one with the highest priority is chosen, and on equal priorities the lowest index wins. Its index and priority appear on `wake_id` and `wake_lvl` from the cycle the clocks return.
- R6: On an interrupt wake, `resume` pulses when the chosen priority is less than or equal to `cpu_prio`, and `exc_req` pulses when it is greater. The pulse lasts one cycle and appears in the first cycle with `cpu_clk_en` back at 1, one clock after the wake event is sampled.
- R7: A `wdt_to` sampled in Sleep wakes the core with a `resume` pulse. It sets `wdto_flag` and `sleep_flag` and does not reset anything.
- R8: A `rst_src` sampled in Sleep or Idle returns to the running state on the next cycle with no `resume` or `exc_req` pulse. It takes precedence over a simultaneous interrupt or time-out, and it sets `sleep_flag` only when leaving Sleep.
- R9: `sleep_flag` and `wdto_flag` never fall except under power-on reset, which clears both.
- R10: Any wake from Idle restores `cpu_clk_en` in the next cycle and does not set `sleep_flag`. A watchdog wake from Idle sets `wdto_flag` and pulses `resume`.
- R11: A `wdt_to` sampled in the running state has no effect: there is no pulse and `wdto_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_src | input | 1 | Any other reset source, synchronous |
| ps_req | input | 1 | Power-save request from the core |
| ps_mode | input | 1 | 0 = Sleep, 1 = Idle |
| irq_pend | input | NSRC | Pending interrupt requests |
| irq_en | input | NSRC | Per-source enable bits |
| irq_prio | input | NSRC*PW | Per-source priority, source i at bits i*PW +: PW |
| cpu_prio | input | PW | Current CPU priority |
| wdt_to | input | 1 | Watchdog time-out strobe |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| wdt_clr | output | 1 | Watchdog clear pulse on Idle entry |
| resume | output | 1 | Continue after the power-save instruction |
| exc_req | output | 1 | Start exception entry |
| wake_id | output | IW | Index of the waking source |
| wake_lvl | output | PW | Priority of the waking source |
| sleep_flag | output | 1 | Sticky: woke from Sleep |
| wdto_flag | output | 1 | Sticky: watchdog time-out wake |

## Verification
The assertions check the following properties on every cycle. The resume and exception strobes are one cycle long, never both high, and arrive only as the CPU clock comes back. An exception strobe always carries a priority above the CPU priority. Sleep never leaves the CPU clock on. The status flags never drop, and without a qualifying event the core stays parked. The bench scenarios cover the rest: the priority comparison across every level pair in both modes, the arbitration across every pair of priorities, reset precedence, the Idle watchdog clear, and the separation of Idle wakes from Sleep wakes in the flags.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int NSRC = 4,
  parameter int PW = 3,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_src,
  input  logic            ps_req,
  input  logic            ps_mode,
  input  logic [NSRC-1:0] irq_pend,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC*PW-1:0] irq_prio,
  input  logic [PW-1:0]   cpu_prio,
  input  logic            wdt_to,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            wdt_clr,
  output logic            resume,
  output logic            exc_req,
  output logic [IW-1:0]   wake_id,
  output logic [PW-1:0]   wake_lvl,
  output logic            sleep_flag,
  output logic            wdto_flag
);

  typedef enum logic [1:0] {S_RUN, S_SLEEP, S_IDLE} st_t;
  st_t st;

  logic [PW-1:0] best_lvl;
  logic [IW-1:0] best_id;
  logic          irq_wake;

  always_comb begin
    best_lvl = '0;
    best_id  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_en[i] && irq_pend[i] && (irq_prio[i*PW +: PW] > best_lvl)) begin
        best_lvl = irq_prio[i*PW +: PW];
        best_id  = IW'(i);
      end
    end
  end

  assign irq_wake   = (best_lvl != '0);
  assign cpu_clk_en = (st == S_RUN);
  assign per_clk_en = (st != S_SLEEP);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st         <= S_RUN;
      resume     <= 1'b0;
      exc_req    <= 1'b0;
      wdt_clr    <= 1'b0;
      wake_id    <= '0;
      wake_lvl   <= '0;
      sleep_flag <= 1'b0;
      wdto_flag  <= 1'b0;
    end else begin
      resume  <= 1'b0;
      exc_req <= 1'b0;
      wdt_clr <= 1'b0;
      if (rst_src) begin
        if (st == S_SLEEP) sleep_flag <= 1'b1;
        st <= S_RUN;
      end else if (st == S_RUN) begin
        if (ps_req) begin
          st      <= ps_mode ? S_IDLE : S_SLEEP;
          wdt_clr <= ps_mode;
        end
      end else if (irq_wake || wdt_to) begin
        st <= S_RUN;
        if (st == S_SLEEP) sleep_flag <= 1'b1;
        if (wdt_to) wdto_flag <= 1'b1;
        if (irq_wake) begin
          wake_id  <= best_id;
          wake_lvl <= best_lvl;
          if (best_lvl > cpu_prio) exc_req <= 1'b1;
          else                     resume  <= 1'b1;
        end else begin
          resume <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int NSRC = 4,
  parameter int PW = 3,
  parameter int IW = 2
) (
  input logic            clk,
  input logic            por_n,
  input logic            rst_src,
  input logic [NSRC-1:0] irq_pend,
  input logic [NSRC-1:0] irq_en,
  input logic [NSRC*PW-1:0] irq_prio,
  input logic [PW-1:0]   cpu_prio,
  input logic            wdt_to,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic            wdt_clr,
  input logic            resume,
  input logic            exc_req,
  input logic [PW-1:0]   wake_lvl,
  input logic            sleep_flag,
  input logic            wdto_flag
);

  logic any_q;
  always_comb begin
    any_q = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (irq_en[i] && irq_pend[i] && (irq_prio[i*PW +: PW] != '0)) any_q = 1'b1;
  end

  p_excl_r6: assert property (@(posedge clk) disable iff (!por_n) !(resume && exc_req));
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!por_n)
    (resume || exc_req) |=> !(resume || exc_req));
  p_on_restore_r6: assert property (@(posedge clk) disable iff (!por_n)
    (resume || exc_req) |-> (cpu_clk_en && !$past(cpu_clk_en)));
  p_exc_above_r6: assert property (@(posedge clk) disable iff (!por_n)
    exc_req |-> (wake_lvl > $past(cpu_prio)));
  p_sleep_gates_r2: assert property (@(posedge clk) disable iff (!por_n)
    !per_clk_en |-> !cpu_clk_en);
  p_idle_clr_r2: assert property (@(posedge clk) disable iff (!por_n)
    wdt_clr |-> (!cpu_clk_en && per_clk_en && $past(cpu_clk_en)));
  p_parked_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_clk_en && !rst_src && !wdt_to && !any_q) |=> !cpu_clk_en);
  p_sleep_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    sleep_flag |=> sleep_flag);
  p_wdto_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
    wdto_flag |=> wdto_flag);

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_src(rst_src), .irq_pend(irq_pend),
  .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio), .wdt_to(wdt_to),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .wdt_clr(wdt_clr),
  .resume(resume), .exc_req(exc_req), .wake_lvl(wake_lvl),
  .sleep_flag(sleep_flag), .wdto_flag(wdto_flag)
);

// File: tb/pwr_mode_ctl_bench.sv
module pwr_mode_ctl_bench;
  localparam int NSRC = 4;
  localparam int PW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_src = 1'b0, ps_req = 1'b0, ps_mode = 1'b0, wdt_to = 1'b0;
  logic [NSRC-1:0] irq_pend = '0, irq_en = '0;
  logic [NSRC*PW-1:0] irq_prio = '0;
  logic [PW-1:0] cpu_prio = '0;
  logic cpu_clk_en, per_clk_en, wdt_clr, resume, exc_req, sleep_flag, wdto_flag;
  logic [IW-1:0] wake_id;
  logic [PW-1:0] wake_lvl;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwr_mode_ctl #(.NSRC(NSRC), .PW(PW)) u_pwr_mode_ctl (
    .clk(clk), .por_n(por_n), .rst_src(rst_src), .ps_req(ps_req), .ps_mode(ps_mode),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio), .cpu_prio(cpu_prio),
    .wdt_to(wdt_to), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .wdt_clr(wdt_clr), .resume(resume), .exc_req(exc_req), .wake_id(wake_id),
    .wake_lvl(wake_lvl), .sleep_flag(sleep_flag), .wdto_flag(wdto_flag));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic por();
    por_n = 1'b0; rst_src = 0; ps_req = 0; wdt_to = 0;
    irq_pend = '0; irq_en = '0; irq_prio = '0; cpu_prio = '0;
    #2; por_n = 1'b1;
    tick();
  endtask

  task automatic src(input int i, input logic en, input logic pd, input int lvl);
    irq_en[i] = en; irq_pend[i] = pd; irq_prio[i*PW +: PW] = PW'(lvl);
  endtask

  task automatic enter(input logic m);
    ps_req = 1'b1; ps_mode = m;
    tick();
    ps_req = 1'b0;
  endtask

  task automatic leave();
    rst_src = 1'b1; tick(); rst_src = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1; por();
    // R1 reset state
    chk("R1 cpu_clk_en", cpu_clk_en, 1); chk("R1 per_clk_en", per_clk_en, 1);
    chk("R1 pulses", {resume, exc_req, wdt_clr}, 0);
    chk("R1 flags", {sleep_flag, wdto_flag}, 0);

    // R2 entry and wdt_clr; R3 ignored requests; R10 idle wake keeps sleep_flag 0
    enter(1'b0);
    chk("R2 sleep enables", {cpu_clk_en, per_clk_en}, 0); chk("R2 no clr sleep", wdt_clr, 0);
    ps_req = 1; ps_mode = 1; tick(); ps_req = 0;
    chk("R3 req in sleep", {cpu_clk_en, per_clk_en}, 0);
    leave();
    chk("R8 sleep flag by reset", sleep_flag, 1); chk("R8 no pulse", {resume, exc_req}, 0);
    chk("R8 back to run", cpu_clk_en, 1);
    por();
    chk("R9 por clears", sleep_flag, 0);
    enter(1'b1);
    chk("R2 idle enables", {cpu_clk_en, per_clk_en}, 1); chk("R2 clr pulse", wdt_clr, 1);
    ps_req = 1; ps_mode = 0; tick(); ps_req = 0;
    chk("R2 clr once", wdt_clr, 0);
    chk("R3 req in idle", {cpu_clk_en, per_clk_en}, 1);
    leave();
    chk("R8 idle reset no sleep flag", sleep_flag, 0);

    // R11 watchdog in run
    wdt_to = 1; tick(); wdt_to = 0;
    chk("R11 no flag", wdto_flag, 0); chk("R11 no pulse", {resume, exc_req}, 0);

    // R10 watchdog wake from idle; R7 from sleep
    enter(1'b1);
    wdt_to = 1; tick(); wdt_to = 0;
    chk("R10 restore", cpu_clk_en, 1); chk("R10 resume", resume, 1);
    chk("R10 wdto", wdto_flag, 1); chk("R10 sleep flag", sleep_flag, 0);
    por();
    enter(1'b0);
    wdt_to = 1; tick(); wdt_to = 0;
    chk("R7 restore", {cpu_clk_en, per_clk_en}, 3); chk("R7 resume", {resume, exc_req}, 2);
    chk("R7 flags", {sleep_flag, wdto_flag}, 3);

    // R8 reset precedence over a qualifying interrupt
    por();
    enter(1'b0);
    src(0, 1, 1, 7); rst_src = 1; tick(); rst_src = 0; src(0, 0, 0, 0);
    chk("R8 precedence", {resume, exc_req}, 0); chk("R8 run", cpu_clk_en, 1);

    // R4 non-qualifying sources in sleep
    enter(1'b0);
    for (int lv = 0; lv < 8; lv++)
      for (int e = 0; e < 2; e++) begin
        if (lv != 0 && e == 1) continue;
        src(2, e[0], 1, lv); tick();
        chk("R4 no wake", cpu_clk_en, 0);
      end
    src(2, 1, 0, 5); tick(); chk("R4 not pending", cpu_clk_en, 0);
    src(2, 0, 0, 0);
    leave();

    // R6 priority comparison, both modes
    for (int m = 0; m < 2; m++)
      for (int cp = 0; cp < 8; cp++)
        for (int lv = 1; lv < 8; lv++) begin
          enter(m[0]);
          cpu_prio = PW'(cp); src(0, 1, 1, lv);
          tick();
          src(0, 0, 0, 0);
          chk("R6 restore", cpu_clk_en, 1);
          chk("R6 resume", resume, (lv <= cp) ? 1 : 0);
          chk("R6 exc_req", exc_req, (lv > cp) ? 1 : 0);
          chk("R5 lvl", wake_lvl, lv);
          tick();
          chk("R6 single pulse", {resume, exc_req}, 0);
        end

    // R5 arbitration over sources 1 and 3
    cpu_prio = 3'd7;
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        if (a == 0 && b == 0) continue;
        enter(1'b0);
        src(1, 1, 1, a); src(3, 1, 1, b);
        tick();
        src(1, 0, 0, 0); src(3, 0, 0, 0);
        chk("R5 id", wake_id, (a >= b) ? 1 : 3);
        chk("R5 lvl", wake_lvl, (a >= b) ? a : b);
      end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule